// File: doc/BRIEF.md
# Periodic Interrupt Timer

The block divides a single-cycle count-enable tick by a programmable modulus and raises a level interrupt request each time the modulus counter hits zero. Software sees two registers on a small synchronous register bus. A 16-bit control word at offset 0x0 holds an 8-bit priority level, a sticky expiry flag, an interrupt enable, a debug-halt enable and a run enable. A 32-bit word at offset 0x4 holds the 16-bit reload value in its upper half.

The counter steps down by one on each qualifying tick. Once it has reached zero, the next qualifying tick loads the reload value, so expiries are spaced reload+1 ticks apart. Writing the reload register starts a fresh period at once. The expiry flag is cleared by writing one to it. While the flag and the enable are both set, the request output is high and carries the priority level captured when the request rose.

Top module: `prd_irq_timer`

## Requirements
- R1: Control word at offset 0x0 returns in read data bits [15:0] as level [15:8], expiry flag [7], interrupt enable [2], halt enable [1], run enable [0]; bits [6:3] and [31:16] read zero, and write data in bits [6:3] is ignored.
- R2: Reload word at offset 0x4 stores write data [31:16] and reads back as {reload, 16'h0}; write data [15:0] is ignored.
- R3: Synchronous active-high reset clears both registers, the counter, the flag, the read data and the request outputs to zero.
- R4: A tick with run enable 1 and no halt steps the counter: from zero it loads the reload value, otherwise it decrements. The flag sets on the tick whose new count is zero, so expiries repeat every reload+1 ticks. A reload of zero expires on every tick.
- R5: With run enable 0, ticks do not move the counter, and counting resumes from the held value.
- R6: With halt enable 1 the counter does not move while the halt input is high; with halt enable 0 the halt input has no effect.
- R7: Writing the control word with bit 7 set clears the flag; a write with bit 7 clear leaves the flag unchanged.
- R8: When an expiry and a flag-clearing write fall in the same cycle, the flag ends up set.
- R9: A write to the reload word loads the new value into the counter in that cycle, ahead of any tick in the same cycle.
- R10: The request output is high exactly while the flag and the interrupt enable are both set. It changes in the same cycle as the register state that drives it.
- R11: The level output is zero while no request is active. It takes the level field's value in the cycle the request rises and holds that value while the request stays high, even if the level field is rewritten.
- R12: Read data is registered and appears in the cycle after a read strobe, then holds until the next read. Unmapped offsets read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable pulse, one cycle per count |
| halt | input | 1 | Debug halt request |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_req | output | 1 | Level interrupt request |
| irq_level | output | 8 | Priority carried with the request |

## Verification
On every cycle the in-line assertions enforce several properties. The request output must track flag AND enable. The counter must stay put when the run enable is off or the halt is active, and a reload write must land in the counter. An expiry must win over a clear, a clear without an expiry must drop the flag, the level output must not move during an active request, and reserved fields must read zero. Only the bench's scenarios show the period length (reload+1 ticks, with the reload-of-zero case) and that a reload write restarts the period mid-count. They also show that a halt with the halt enable off is ignored and that counting resumes from a held value. A behavioural model, compared on every clock, catches timing slips of a single cycle in request, level and read data.

// File: rtl/prd_irq_pkg.sv
package prd_irq_pkg;

  // Priority level width and control word bit positions
  localparam int LVL_W    = 8;
  localparam int TE_BIT   = 0;
  localparam int FE_BIT   = 1;
  localparam int IE_BIT   = 2;
  localparam int RSVD_LO  = 3;
  localparam int RSVD_HI  = 6;
  localparam int FLAG_BIT = 7;
  localparam int LVL_LSB  = 8;
  localparam int CTL_W    = LVL_LSB + LVL_W;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic             ie;
    logic             fe;
    logic             te;
  } ctl_t;

endpackage

// File: rtl/prd_regs.sv
module prd_regs
  import prd_irq_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int CTL_OFS = 0,
  parameter int PRE_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              flag_q,
  output ctl_t              ctl_q,
  output ctl_t              ctl_d,
  output logic [CNT_W-1:0]  preload_q,
  output logic              pre_wr,
  output logic [CNT_W-1:0]  pre_val,
  output logic              clr_req,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] PRE_A = ADDR_W'(PRE_OFS);

  logic              ctl_wr;
  logic              rd_stb;
  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] pre_word;
  logic [DATA_W-1:0] rd_mux;

  assign ctl_wr  = bus_en && bus_we && (bus_addr == CTL_A);
  assign pre_wr  = bus_en && bus_we && (bus_addr == PRE_A);
  assign rd_stb  = bus_en && !bus_we;
  assign pre_val = bus_wdata[DATA_W-1 -: CNT_W];
  assign clr_req = ctl_wr && bus_wdata[FLAG_BIT];

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d.lvl = bus_wdata[LVL_LSB +: LVL_W];
      ctl_d.ie  = bus_wdata[IE_BIT];
      ctl_d.fe  = bus_wdata[FE_BIT];
      ctl_d.te  = bus_wdata[TE_BIT];
    end
  end

  always_comb begin
    ctl_word                    = '0;
    ctl_word[LVL_LSB +: LVL_W]  = ctl_q.lvl;
    ctl_word[FLAG_BIT]          = flag_q;
    ctl_word[IE_BIT]            = ctl_q.ie;
    ctl_word[FE_BIT]            = ctl_q.fe;
    ctl_word[TE_BIT]            = ctl_q.te;
    pre_word                    = '0;
    pre_word[DATA_W-1 -: CNT_W] = preload_q;
    if (bus_addr == CTL_A)      rd_mux = ctl_word;
    else if (bus_addr == PRE_A) rd_mux = pre_word;
    else                        rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      preload_q <= '0;
      rdata     <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (pre_wr) preload_q <= pre_val;
      if (rd_stb) rdata <= rd_mux;
    end
  end

  AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && bus_addr == CTL_A) |=> (rdata[RSVD_HI:RSVD_LO] == '0 && rdata[DATA_W-1:CTL_W] == '0)); // R1

  AST_RSVD_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && |bus_wdata[RSVD_HI:RSVD_LO]) |=> (ctl_q.te == $past(bus_wdata[TE_BIT]))); // R1

  AST_PRE_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && bus_addr == PRE_A) |=> (rdata[DATA_W-CNT_W-1:0] == '0)); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb && !$past(rst)) |=> $stable(rdata)); // R12

endmodule

// File: rtl/prd_counter.sv
module prd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             te,
  input  logic             fe,
  input  logic             halt,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic             hit
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             adv;

  assign adv     = tick && te && !(fe && halt);
  assign cnt_nxt = (cnt == '0) ? reload_val : cnt - 1'b1;
  assign hit     = adv && !load && (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (adv)  cnt <= cnt_nxt;
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!te && !load) |=> $stable(cnt)); // R5

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (fe && halt && !load) |=> $stable(cnt)); // R6

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val))); // R9

endmodule

// File: rtl/prd_irq_out.sv
module prd_irq_out
  import prd_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             clr_req,
  input  logic             ie_q,
  input  logic             ie_d,
  input  logic [LVL_W-1:0] lvl_d,
  output logic             flag_q,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level
);

  logic flag_d;
  logic req_d;

  always_comb begin
    if (hit)          flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  assign req_d = flag_d && ie_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b0;
      irq_req   <= 1'b0;
      irq_level <= '0;
    end else begin
      flag_q  <= flag_d;
      irq_req <= req_d;
      if (!req_d)       irq_level <= '0;
      else if (!irq_req) irq_level <= lvl_d;
    end
  end

  AST_REQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_req == (flag_q && ie_q)); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q); // R8

  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !hit) |=> !flag_q); // R7

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> (!irq_req || $stable(irq_level))); // R11

  AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_level == '0)); // R11

endmodule

// File: rtl/prd_irq_timer.sv
module prd_irq_timer
  import prd_irq_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int CTL_OFS = 0,
  parameter int PRE_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              halt,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_level
);

  ctl_t             ctl_q;
  ctl_t             ctl_d;
  logic [CNT_W-1:0] preload_q;
  logic [CNT_W-1:0] pre_val;
  logic             pre_wr;
  logic             clr_req;
  logic             flag_q;
  logic             hit;

  prd_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .CTL_OFS(CTL_OFS),
    .PRE_OFS(PRE_OFS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .flag_q   (flag_q),
    .ctl_q    (ctl_q),
    .ctl_d    (ctl_d),
    .preload_q(preload_q),
    .pre_wr   (pre_wr),
    .pre_val  (pre_val),
    .clr_req  (clr_req),
    .rdata    (bus_rdata)
  );

  prd_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .te        (ctl_q.te),
    .fe        (ctl_q.fe),
    .halt      (halt),
    .load      (pre_wr),
    .load_val  (pre_val),
    .reload_val(preload_q),
    .hit       (hit)
  );

  prd_irq_out u_irq (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .clr_req  (clr_req),
    .ie_q     (ctl_q.ie),
    .ie_d     (ctl_d.ie),
    .lvl_d    (ctl_d.lvl),
    .flag_q   (flag_q),
    .irq_req  (irq_req),
    .irq_level(irq_level)
  );

endmodule

// File: tb/sim_prd_irq_timer.sv
module sim_prd_irq_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        halt = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_level;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  prd_irq_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .halt(halt),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  // Behavioural reference model
  logic [7:0]  m_lvl, m_lvlout;
  logic        m_ie, m_fe, m_te, m_flag, m_req;
  int          m_pre, m_cnt;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_lvl = 0; m_lvlout = 0; m_ie = 0; m_fe = 0; m_te = 0;
      m_flag = 0; m_req = 0; m_pre = 0; m_cnt = 0; m_rd = 0;
    end else begin
      bit ctlw, prew, adv, hitm, nreq;
      int nc;
      ctlw = bus_en && bus_we && bus_addr == 3'd0;
      prew = bus_en && bus_we && bus_addr == 3'd4;
      if (bus_en && !bus_we) begin
        if (bus_addr == 3'd0)
          m_rd = {16'h0, m_lvl, m_flag, 4'h0, m_ie, m_fe, m_te};
        else if (bus_addr == 3'd4)
          m_rd = {m_pre[15:0], 16'h0};
        else
          m_rd = 0;
      end
      adv = tick && m_te && !(m_fe && halt);
      hitm = 0;
      if (prew) m_cnt = int'(bus_wdata[31:16]);
      else if (adv) begin
        nc = (m_cnt == 0) ? m_pre : m_cnt - 1;
        hitm = (nc == 0);
        m_cnt = nc;
      end
      if (prew) m_pre = int'(bus_wdata[31:16]);
      if (ctlw) begin
        m_lvl = bus_wdata[15:8]; m_ie = bus_wdata[2];
        m_fe = bus_wdata[1]; m_te = bus_wdata[0];
      end
      if (hitm) m_flag = 1;
      else if (ctlw && bus_wdata[7]) m_flag = 0;
      nreq = m_flag && m_ie;
      if (!nreq) m_lvlout = 0;
      else if (!m_req) m_lvlout = m_lvl;
      m_req = nreq;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq_req !== m_req) begin
        failures++;
        $display("FAIL R10 irq_req act=%0b exp=%0b", irq_req, m_req);
      end
      checks++;
      if (irq_level !== m_lvlout) begin
        failures++;
        $display("FAIL R11 irq_level act=%0h exp=%0h", irq_level, m_lvlout);
      end
      checks++;
      if (bus_rdata !== m_rd) begin
        failures++;
        $display("FAIL R12 bus_rdata act=%0h exp=%0h", bus_rdata, m_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R3 reset state
    chk("R3 irq_req", {31'h0, irq_req}, 0);
    rd(0, d); chk("R3 ctl", d, 0);
    rd(4, d); chk("R3 reload", d, 0);
    // R2 reload register
    wr(4, 32'h0003_BEEF);
    rd(4, d); chk("R2 reload readback", d, 32'h0003_0000);
    // R1 reserved bits ignored
    wr(0, 32'hFFFF_5A7D);
    rd(0, d); chk("R1 ctl readback", d, 32'h0000_5A05);
    // R4 first expiry after 3 ticks
    tk(2); chk("R4 no expiry yet", {31'h0, irq_req}, 0);
    tk(1); chk("R4 expiry", {31'h0, irq_req}, 1);
    chk("R11 level", {24'h0, irq_level}, 32'h5A);
    // R7 write zero keeps, write one clears
    wr(0, 32'h0000_5A05); chk("R7 zero write keeps", {31'h0, irq_req}, 1);
    wr(0, 32'h0000_5A85); chk("R7 clear", {31'h0, irq_req}, 0);
    rd(0, d); chk("R7 flag read", d, 32'h0000_5A05);
    // R4 period reload+1
    tk(3); chk("R4 period short", {31'h0, irq_req}, 0);
    tk(1); chk("R4 period", {31'h0, irq_req}, 1);
    // R11 level held while asserted
    wr(0, 32'h0000_3305); chk("R11 held", {24'h0, irq_level}, 32'h5A);
    rd(0, d); chk("R11 field updated", d, 32'h0000_3385);
    wr(0, 32'h0000_3385); chk("R11 idle zero", {24'h0, irq_level}, 0);
    tk(4); chk("R11 new level", {24'h0, irq_level}, 32'h33);
    // R10 enable gating
    wr(0, 32'h0000_3381); tk(4);
    chk("R10 masked", {31'h0, irq_req}, 0);
    rd(0, d); chk("R10 flag pending", d, 32'h0000_3381);
    wr(0, 32'h0000_3305); chk("R10 unmask", {31'h0, irq_req}, 1);
    // R5 hold mid-count
    wr(0, 32'h0000_3384); wr(4, 32'h0005_0000);
    tk(10); chk("R5 held", {31'h0, irq_req}, 0);
    wr(0, 32'h0000_3305);
    tk(4); chk("R5 resume short", {31'h0, irq_req}, 0);
    tk(1); chk("R5 resume", {31'h0, irq_req}, 1);
    // R6 halt with halt enable
    wr(0, 32'h0000_3387); wr(4, 32'h0003_0000);
    halt = 1; tk(10); chk("R6 halted", {31'h0, irq_req}, 0);
    halt = 0; tk(2); chk("R6 resume short", {31'h0, irq_req}, 0);
    tk(1); chk("R6 resume", {31'h0, irq_req}, 1);
    // R6 halt ignored without halt enable
    wr(0, 32'h0000_3385); halt = 1;
    tk(3); chk("R6 ignored short", {31'h0, irq_req}, 0);
    tk(1); chk("R6 ignored", {31'h0, irq_req}, 1);
    halt = 0;
    // R8 set wins over clear
    wr(0, 32'h0000_3385); wr(4, 32'h0002_0000); tk(1);
    @(negedge clk); tick = 1; bus_en = 1; bus_we = 1; bus_addr = 0; bus_wdata = 32'h0000_3385;
    @(negedge clk); tick = 0; bus_en = 0; bus_we = 0;
    chk("R8 set wins", {31'h0, irq_req}, 1);
    rd(0, d); chk("R8 flag", d, 32'h0000_3385);
    // R9 reload write restarts
    wr(0, 32'h0000_3385); tk(2);
    wr(4, 32'h0006_0000);
    tk(1); chk("R9 restarted", {31'h0, irq_req}, 0);
    tk(4); chk("R9 short", {31'h0, irq_req}, 0);
    tk(1); chk("R9 expiry", {31'h0, irq_req}, 1);
    // R4 reload zero expires every tick
    wr(0, 32'h0000_3385); wr(4, 32'h0000_0000);
    tk(1); chk("R4 zero reload", {31'h0, irq_req}, 1);
    wr(0, 32'h0000_3385); chk("R4 cleared", {31'h0, irq_req}, 0);
    tk(1); chk("R4 zero reload again", {31'h0, irq_req}, 1);
    // R12 unmapped offsets
    rd(2, d); chk("R12 unmapped read", d, 0);
    wr(6, 32'hFFFF_FFFF);
    rd(0, d); chk("R12 unmapped write ctl", d, 32'h0000_3385);
    rd(4, d); chk("R12 unmapped write reload", d, 0);
    // R3 reset mid-run
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    chk("R3 irq after reset", {31'h0, irq_req}, 0);
    chk("R3 rdata after reset", bus_rdata, 0);
    rd(0, d); chk("R3 ctl after reset", d, 0);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule